// File: doc/BRIEF.md
# Character LCD Start-Up Sequencer

This block takes a parallel character display from a cold reset to a working state and then prints one fixed message on it. After a long power-on wait it sends the display's wake-up series in 8-bit form. Next it sends a single nibble that switches the panel to a 4-bit bus. It then sends four configuration commands, each followed by a settle gap. Last, it streams the characters of a built-in text, stopping at the first zero byte, and parks in a done state for good.

The block never drives the display pins itself. Every transfer goes to a downstream write engine as a one-cycle request carrying a data byte, a register-select bit and a flag that asks for a lone upper nibble instead of a full byte. The engine raises busy while it works, and the sequencer moves on only after busy has risen and fallen again. All wait lengths are derived from a clock-frequency parameter and two microsecond parameters. A synchronous reset restarts the whole sequence.

Top module: `lcd_init_seq`

## Requirements
- R1: After reset is released, wr_req, wr_nibble_only, wr_rs, wr_data and done stay low for exactly P = CLK_HZ*POWERUP_US/1e6 cycles. The first request appears in cycle P, where the first cycle after the reset edge is cycle 0.
- R2: The first three requests are lone nibbles (wr_nibble_only=1, wr_rs=0) with wr_data=0x30. The fourth is a lone nibble with wr_data=0x20. The nibble sits in bits 7:4 and bits 3:0 are zero.
- R3: Next come four full-byte commands (wr_nibble_only=0, wr_rs=0) in this order: 0x28, 0x0C, 0x01, 0x06.
- R4: After each of those eight configuration transfers, if busy is first seen low again in cycle b, the next request comes in cycle b+1+G, where G = CLK_HZ*GAP_US/1e6.
- R5: The message bytes (default text "HI THERE") go out in order as data writes (wr_rs=1, wr_nibble_only=0) with no gap. If busy falls in cycle b, the next character is requested in cycle b+1.
- R6: wr_req is high for one cycle only. After a request the block waits for busy to go high and then low, for as long as busy stays high, and never requests in the cycle in which busy falls.
- R7: The zero terminator is never sent. If busy for the last character falls in cycle b, cycle b+1 has no request, and done goes high in cycle b+2. Done then stays high with no further requests, whatever busy does.
- R8: Whenever wr_req is low, wr_nibble_only, wr_rs and wr_data are all zero.
- R9: Synchronous reset overrides everything, including a cycle in which a request is being issued. The sequence restarts from the power-on wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_busy | input | 1 | Write engine busy with the current transfer |
| wr_req | output | 1 | One-cycle transfer request |
| wr_nibble_only | output | 1 | Send only the upper nibble of wr_data |
| wr_rs | output | 1 | 1 for character data, 0 for command |
| wr_data | output | 8 | Byte (or nibble in bits 7:4) to transfer |
| done | output | 1 | Message finished, block idle forever |

## Verification
A synchronous reset and an issued request can land in the same cycle. The bench provokes this by raising reset during the very cycle in which it sees the request for the sixth configuration step. It then judges that reset won: the next cycles show no request and no done, and the first nibble returns only after the full power-on wait. In a second pattern the engine holds busy for up to twenty cycles. There the bench judges that no request appears in the cycle busy falls and that the gaps count from that fall.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int CFG_STEPS = 8;

    typedef enum logic [2:0] {
        ST_POWER,
        ST_ISSUE,
        ST_ACK,
        ST_BUSY,
        ST_GAP,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic       nibble_only;
        logic       rs;
        logic [7:0] data;
    } xfer_t;

endpackage

// File: rtl/lcd_cfg_table.sv
module lcd_cfg_table
    import lcd_seq_pkg::*;
#(
    parameter int SW = 3
)(
    input  logic [SW-1:0] step,
    output xfer_t         item
);

    always_comb begin
        item = '{nibble_only: 1'b0, rs: 1'b0, data: 8'h00};
        case (int'(step))
            0, 1, 2: item = '{nibble_only: 1'b1, rs: 1'b0, data: 8'h30};
            3:       item = '{nibble_only: 1'b1, rs: 1'b0, data: 8'h20};
            4:       item.data = 8'h28;
            5:       item.data = 8'h0C;
            6:       item.data = 8'h01;
            7:       item.data = 8'h06;
            default: item.data = 8'h00;
        endcase
    end

endmodule

// File: rtl/lcd_text_rom.sv
module lcd_text_rom #(
    parameter int             AW   = 5,
    parameter int             LEN  = 8,
    parameter logic [8*LEN-1:0] TEXT = "HI THERE"
)(
    input  logic [AW-1:0] addr,
    output logic [7:0]    ch
);

    always_comb begin
        ch = 8'h00;
        for (int k = 0; k < LEN; k++) begin
            if (int'(addr) == k) ch = TEXT[8*(LEN-1-k) +: 8];
        end
    end

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
    import lcd_seq_pkg::*;
#(
    parameter int unsigned      CLK_HZ     = 50_000_000,
    parameter int unsigned      POWERUP_US = 1_000_000,
    parameter int unsigned      GAP_US     = 5_000,
    parameter int               MSG_LEN    = 8,
    parameter logic [8*MSG_LEN-1:0] MSG_TEXT = "HI THERE"
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_busy,
    output logic       wr_req,
    output logic       wr_nibble_only,
    output logic       wr_rs,
    output logic [7:0] wr_data,
    output logic       done
);

    localparam longint unsigned PWR_RAW = (64'(CLK_HZ) * 64'(POWERUP_US)) / 64'd1_000_000;
    localparam longint unsigned GAP_RAW = (64'(CLK_HZ) * 64'(GAP_US)) / 64'd1_000_000;
    localparam longint unsigned PWR_CYC = (PWR_RAW < 64'd1) ? 64'd1 : PWR_RAW;
    localparam longint unsigned GAP_CYC = (GAP_RAW < 64'd1) ? 64'd1 : GAP_RAW;
    localparam longint unsigned CNT_MAX = (PWR_CYC > GAP_CYC) ? PWR_CYC : GAP_CYC;
    localparam int              CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0]   PWR_LAST = CW'(PWR_CYC - 1);
    localparam logic [CW-1:0]   GAP_LAST = CW'(GAP_CYC - 1);
    localparam int              IW      = $clog2(CFG_STEPS + MSG_LEN + 1);
    localparam int              SW      = $clog2(CFG_STEPS);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
    } seq_regs_t;

    seq_regs_t     regs_q, regs_d;
    logic          in_cfg;
    logic          at_end;
    logic          issue;
    logic [IW-1:0] txt_addr;
    logic [7:0]    txt_ch;
    xfer_t         cfg_item;
    xfer_t         cur_item;

    assign in_cfg   = regs_q.idx < IW'(CFG_STEPS);
    assign txt_addr = regs_q.idx - IW'(CFG_STEPS);

    lcd_cfg_table #(.SW(SW)) u_cfg (
        .step (regs_q.idx[SW-1:0]),
        .item (cfg_item)
    );

    lcd_text_rom #(.AW(IW), .LEN(MSG_LEN), .TEXT(MSG_TEXT)) u_txt (
        .addr (txt_addr),
        .ch   (txt_ch)
    );

    always_comb begin
        if (in_cfg) cur_item = cfg_item;
        else        cur_item = '{nibble_only: 1'b0, rs: 1'b1, data: txt_ch};
        at_end = !in_cfg && (txt_ch == 8'h00);
    end

    always_comb begin
        regs_d = regs_q;
        issue  = 1'b0;
        case (regs_q.state)
            ST_POWER: begin
                if (regs_q.cnt == PWR_LAST) begin
                    regs_d.state = ST_ISSUE;
                    regs_d.cnt   = '0;
                end else begin
                    regs_d.cnt = regs_q.cnt + 1'b1;
                end
            end
            ST_ISSUE: begin
                if (at_end) begin
                    regs_d.state = ST_DONE;
                end else begin
                    issue        = 1'b1;
                    regs_d.state = ST_ACK;
                end
            end
            ST_ACK: begin
                if (wr_busy) regs_d.state = ST_BUSY;
            end
            ST_BUSY: begin
                if (!wr_busy) begin
                    regs_d.idx = regs_q.idx + 1'b1;
                    if (in_cfg) begin
                        regs_d.state = ST_GAP;
                        regs_d.cnt   = '0;
                    end else begin
                        regs_d.state = ST_ISSUE;
                    end
                end
            end
            ST_GAP: begin
                if (regs_q.cnt == GAP_LAST) begin
                    regs_d.state = ST_ISSUE;
                    regs_d.cnt   = '0;
                end else begin
                    regs_d.cnt = regs_q.cnt + 1'b1;
                end
            end
            default: regs_d = regs_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '{state: ST_POWER, cnt: '0, idx: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign wr_req = issue;
    assign {wr_nibble_only, wr_rs, wr_data} = issue ? cur_item : '0;
    assign done   = (regs_q.state == ST_DONE);

endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_busy,
    input logic       wr_req,
    input logic       wr_nibble_only,
    input logic       wr_rs,
    input logic [7:0] wr_data,
    input logic       done
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wr_req && !done));                          // R9

    AST_NIBBLE_CMD: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_nibble_only) |-> (!wr_rs && wr_data[3:0] == 4'h0)); // R2

    AST_DATA_FULL: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_rs) |-> !wr_nibble_only);                       // R5

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> !wr_req);                                           // R6

    AST_NO_REQ_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_busy) |-> !wr_req);                                   // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done |=> done);                                                // R7

    AST_DONE_SILENT: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_req);                                             // R7

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !wr_req |-> (!wr_nibble_only && !wr_rs && wr_data == 8'h00));  // R8

endmodule

bind lcd_init_seq lcd_init_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_busy        (wr_busy),
    .wr_req         (wr_req),
    .wr_nibble_only (wr_nibble_only),
    .wr_rs          (wr_rs),
    .wr_data        (wr_data),
    .done           (done)
);

// File: tb/sim_lcd_init_seq.sv
`timescale 1ns/1ps
module sim_lcd_init_seq;

    localparam int P_CYC  = 30;
    localparam int G_CYC  = 7;
    localparam int NITEMS = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_busy = 1'b0;
    logic       wr_req, wr_nibble_only, wr_rs, done;
    logic [7:0] wr_data;

    always #2.5 clk = ~clk;

    lcd_init_seq #(
        .CLK_HZ(1_000_000), .POWERUP_US(P_CYC), .GAP_US(G_CYC)
    ) u0 (
        .clk(clk), .rst(rst), .wr_busy(wr_busy), .wr_req(wr_req),
        .wr_nibble_only(wr_nibble_only), .wr_rs(wr_rs), .wr_data(wr_data),
        .done(done)
    );

    int    total = 0, bad = 0;
    int    t = 0, item = 0, next_t = P_CYC, eng_cnt = 0, mode = 0;
    bit    last_req = 0;
    int    req_item = 0;
    string rst_tag = "";
    string text = "HI THERE";

    function automatic int blen(int i);
        if (mode == 0) return 1 + (i % 3);
        return 4 + ((i * 5) % 17);
    endfunction

    function automatic logic [9:0] exp_fields(int i);
        case (i)
            0, 1, 2: return {2'b10, 8'h30};
            3:       return {2'b10, 8'h20};
            4:       return {2'b00, 8'h28};
            5:       return {2'b00, 8'h0C};
            6:       return {2'b00, 8'h01};
            7:       return {2'b00, 8'h06};
            default: return {2'b01, 8'(text[i-8])};
        endcase
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s t=%0d actual=%0h expected=%0h", tag, what, t, act, expv);
        end
    endtask

    task automatic tick();
        bit         was_rst, er, ed;
        logic [9:0] ef, got;
        string      tg;
        @(posedge clk);
        was_rst = rst;
        @(negedge clk);
        last_req = 0;
        if (was_rst) begin
            t = 0; item = 0; next_t = P_CYC; eng_cnt = 0; wr_busy = 1'b0;
        end else begin
            t++;
        end
        er = (item < NITEMS) && (t == next_t);
        ed = (item == NITEMS) && (t > next_t);
        ef = er ? exp_fields(item) : 10'd0;
        if (er)                       tg = (item < 4) ? "R2" : (item < 8) ? "R3" : "R5";
        else if (t < P_CYC)           tg = "R1";
        else if (item == NITEMS)      tg = "R7";
        else if (wr_busy)             tg = "R6";
        else if (item <= 8)           tg = "R4";
        else                          tg = "R5";
        if (rst_tag.len() > 0 && t <= P_CYC) tg = rst_tag;
        got = {wr_nibble_only, wr_rs, wr_data};
        chk(wr_req == er, tg, "req", int'(wr_req), int'(er));
        chk(got == ef, er ? tg : "R8", "fields", int'(got), int'(ef));
        chk(done == ed, ed ? "R7" : tg, "done", int'(done), int'(ed));
        if (er) begin
            last_req = 1;
            req_item = item;
            next_t   = t + blen(item) + 2 + ((item < 8) ? G_CYC : 0);
            item++;
        end
        if (eng_cnt > 0) begin
            wr_busy = 1'b1;
            eng_cnt--;
        end else begin
            wr_busy = 1'b0;
        end
        if (wr_req && !was_rst) eng_cnt = er ? blen(req_item) : 1;
    endtask

    task automatic run_to_idle();
        for (int n = 0; n < 5000; n++) begin
            tick();
            if (item == NITEMS && t > next_t + 30) return;
        end
        total++; bad++;
        $display("FAIL R7 watchdog actual=not_done expected=done");
    endtask

    initial begin
        // pattern A: short busy pulses, normal power-up (R1..R8)
        mode = 0;
        rst  = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        run_to_idle();

        // pattern B: long busy, then reset collides with a request (R9, R6)
        mode = 1;
        rst  = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
        for (int n = 0; n < 5000; n++) begin
            tick();
            if (last_req && req_item == 5) break;
        end
        chk(last_req && req_item == 5, "R9", "collision_reached", req_item, 5);
        rst = 1'b1;
        rst_tag = "R9";
        tick();
        rst = 1'b0;
        run_to_idle();
        rst_tag = "";

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL R7 global watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule